// File: doc/BRIEF.md
# Dual-Group Bidirectional Bus Transceiver Core

This block is the system data path of a two-group, non-inverting bus transceiver. Each group carries nine bits between an A side and a B side. Each group has its own active-low output enable and its own direction control. Pads are modelled as separate input, output and output-enable vectors for each side, so a pad ring can build the tri-state drivers around the core.

Each group generates two internal active-high enables, one for its A-side drivers and one for its B-side drivers. Both are brought out as ports. A boundary-scan layer can observe them, and it can replace them with its own values through a per-group override. After reset, a group keeps both sides undriven until its enable input has been seen inactive and then active. This keeps a board that is powered up or hot-inserted from driving the bus before its controller has taken charge.

Top module: `dual_xcvr_core`

## Requirements
- R1: The two groups are independent. A group's enables and data depend only on that group's own enable, direction, override and data inputs. Group g occupies bits [9g+8:9g] of every data and pad-enable vector.
- R2: When a group is armed and not overridden, and its enable input is low with direction high, all nine B-side pad enables are 1 and all nine A-side pad enables are 0.
- R3: When a group is armed and not overridden, and its enable input is low with direction low, all nine A-side pad enables are 1 and all nine B-side pad enables are 0.
- R4: When a group is not overridden and its enable input is high, all of its A-side and B-side pad enables are 0, whatever the direction input is.
- R5: After reset a group is unarmed, and its pad enables are 0 while it is unarmed and not overridden. A group becomes armed at the first clock edge that samples its enable input low after an earlier edge, following reset, sampled it high.
- R6: Once armed, a group stays armed until the next reset, whatever its enable input does.
- R7: The A-side and B-side internal enables of each group are output on `a_en_o` and `b_en_o`. Each group's nine pad enables for a side all equal that side's internal enable.
- R8: While a group's override input is 1, its A-side and B-side internal enables equal `scan_a_en_i` and `scan_b_en_i` for that group. This holds regardless of arming, enable or direction.
- R9: Data passes without inversion and without a clock delay: `a_out_o` equals `b_in_i` and `b_out_o` equals `a_in_i`, bit for bit.
- R10: Asserting reset again returns every group to the unarmed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the arming logic |
| rst_n | input | 1 | Synchronous active-low reset |
| oe_n_i | input | 2 | Per-group output enable, active low |
| dir_i | input | 2 | Per-group direction: 1 = A to B, 0 = B to A |
| scan_ovr_i | input | 2 | Per-group scan override select |
| scan_a_en_i | input | 2 | Override value for the A-side enable |
| scan_b_en_i | input | 2 | Override value for the B-side enable |
| a_in_i | input | 18 | A-side pad inputs |
| b_in_i | input | 18 | B-side pad inputs |
| a_out_o | output | 18 | A-side pad output data |
| a_oe_o | output | 18 | A-side pad output enables |
| b_out_o | output | 18 | B-side pad output data |
| b_oe_o | output | 18 | B-side pad output enables |
| a_en_o | output | 2 | Internal A-side enable per group |
| b_en_o | output | 2 | Internal B-side enable per group |

## Verification
The bench concentrates on the power-up lock. It holds the enable low straight out of reset, which must not arm a design that only looks at the level; such a design would drive the bus at once. It then checks that arming takes effect on the edge that samples the low level, one edge too early or late shows up as a mismatch in that cycle. It also checks that a group stays armed after further toggles, and that a second reset brings the lock back. The bench also arms only one group and checks the other stays quiet. This catches crossed group indices or swapped slices. It drives the override while the group is unarmed, which catches a design that still gates scan values with the lock. Random stimulus against the cycle model covers swapped direction and inverted data.

// File: rtl/xcvr_pkg.sv
// Package: shared types for the dual-group transceiver core.
// Assumes: nothing beyond standard SystemVerilog.
package xcvr_pkg;

    // Pair of internal active-high side enables for one group.
    typedef struct packed {
        logic a;   // drives A-side pads
        logic b;   // drives B-side pads
    } side_en_t;

endpackage

// File: rtl/xcvr_pwrup_lock.sv
// Module: per-group power-up lock.
// What it does: after reset, holds 'armed' low until the group's active-low
// enable has been sampled high on one edge and low on a later edge; then
// keeps 'armed' high until the next reset.
// Assumes: oe_n is synchronous to clk.
module xcvr_pwrup_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_n,
    output logic armed
);

    logic seen_idle;

    // Track the inactive level, then the first active level after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_idle <= 1'b0;
            armed     <= 1'b0;
        end else begin
            if (oe_n)
                seen_idle <= 1'b1;
            if (seen_idle && !oe_n)
                armed <= 1'b1;
        end
    end

    // R6: once set, the lock flag never clears without reset.
    p_armed_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);

    // R5: arming requires an idle level seen on an earlier edge.
    p_arm_needs_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> ($past(seen_idle) && !$past(oe_n)));

endmodule

// File: rtl/xcvr_group.sv
// Module: one transceiver group.
// What it does: derives the A-side and B-side enables from lock, enable,
// direction and scan override, and fans them out to per-bit pad enables.
// Data is wired across both sides without inversion.
// Assumes: clk/rst_n are used only by the embedded checks.
module xcvr_group
    import xcvr_pkg::*;
#(
    parameter int GW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          armed,
    input  logic          oe_n,
    input  logic          dir,
    input  logic          ovr,
    input  logic          ovr_a,
    input  logic          ovr_b,
    input  logic [GW-1:0] a_in,
    input  logic [GW-1:0] b_in,
    output logic [GW-1:0] a_out,
    output logic [GW-1:0] a_oe,
    output logic [GW-1:0] b_out,
    output logic [GW-1:0] b_oe,
    output side_en_t      en
);

    side_en_t func_en;

    // Functional enables: lock, active enable, then direction picks a side.
    always_comb begin
        func_en.a = armed && !oe_n && !dir;
        func_en.b = armed && !oe_n &&  dir;
    end

    // Scan override replaces the functional enables when selected.
    always_comb begin
        if (ovr) begin
            en.a = ovr_a;
            en.b = ovr_b;
        end else begin
            en = func_en;
        end
    end

    // Pad-enable fan-out and straight data crossing.
    always_comb begin
        a_oe  = {GW{en.a}};
        b_oe  = {GW{en.b}};
        a_out = b_in;
        b_out = a_in;
    end

    // R4: inactive enable input silences both sides unless overridden.
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr && oe_n) |-> (a_oe == '0 && b_oe == '0));

    // R5: unarmed group drives nothing unless overridden.
    p_locked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr && !armed) |-> (a_oe == '0 && b_oe == '0));

    // R2: armed, enabled, direction high drives only the B side.
    p_dir_ab_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr && armed && !oe_n && dir) |-> (b_oe == '1 && a_oe == '0));

    // R3: armed, enabled, direction low drives only the A side.
    p_dir_ba_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr && armed && !oe_n && !dir) |-> (a_oe == '1 && b_oe == '0));

    // R8: override values reach the side enables.
    p_scan_ovr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> (en.a == ovr_a && en.b == ovr_b));

endmodule

// File: rtl/dual_xcvr_core.sv
// Module: top of the dual-group transceiver core.
// What it does: instantiates one power-up lock and one group datapath per
// group, slicing the flat pad vectors by group index.
// Assumes: group g owns bits [GW*g+GW-1 : GW*g]; synchronous active-low reset.
module dual_xcvr_core
    import xcvr_pkg::*;
#(
    parameter int NGRP = 2,
    parameter int GW   = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NGRP-1:0]      oe_n_i,
    input  logic [NGRP-1:0]      dir_i,
    input  logic [NGRP-1:0]      scan_ovr_i,
    input  logic [NGRP-1:0]      scan_a_en_i,
    input  logic [NGRP-1:0]      scan_b_en_i,
    input  logic [NGRP*GW-1:0]   a_in_i,
    input  logic [NGRP*GW-1:0]   b_in_i,
    output logic [NGRP*GW-1:0]   a_out_o,
    output logic [NGRP*GW-1:0]   a_oe_o,
    output logic [NGRP*GW-1:0]   b_out_o,
    output logic [NGRP*GW-1:0]   b_oe_o,
    output logic [NGRP-1:0]      a_en_o,
    output logic [NGRP-1:0]      b_en_o
);

    localparam int TOTW = NGRP * GW;

    logic [NGRP-1:0] armed;
    side_en_t        grp_en [NGRP];

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int LO = g * GW;

        xcvr_pwrup_lock u_lock (
            .clk   (clk),
            .rst_n (rst_n),
            .oe_n  (oe_n_i[g]),
            .armed (armed[g])
        );

        xcvr_group #(.GW(GW)) u_grp (
            .clk   (clk),
            .rst_n (rst_n),
            .armed (armed[g]),
            .oe_n  (oe_n_i[g]),
            .dir   (dir_i[g]),
            .ovr   (scan_ovr_i[g]),
            .ovr_a (scan_a_en_i[g]),
            .ovr_b (scan_b_en_i[g]),
            .a_in  (a_in_i[LO +: GW]),
            .b_in  (b_in_i[LO +: GW]),
            .a_out (a_out_o[LO +: GW]),
            .a_oe  (a_oe_o[LO +: GW]),
            .b_out (b_out_o[LO +: GW]),
            .b_oe  (b_oe_o[LO +: GW])
            ,.en   (grp_en[g])
        );

        // Expose the internal side enables for scan observation (R7).
        assign a_en_o[g] = grp_en[g].a;
        assign b_en_o[g] = grp_en[g].b;
    end

    // R7: exposed enables never disagree with the pad enables they gate.
    p_en_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(a_oe_o) + $countones(b_oe_o)) ==
        GW * ($countones(a_en_o) + $countones(b_en_o)));

    // R9: data crosses with no inversion.
    p_no_invert_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (a_out_o == b_in_i) && (b_out_o == a_in_i) && (TOTW > 0));

endmodule

// File: tb/dual_xcvr_core_tb.sv
module dual_xcvr_core_tb;

    localparam int NG = 2;
    localparam int W  = 9;

    logic clk = 1'b0;
    logic rst_n;
    logic [NG-1:0]   oe_n, dir, ovr, sa, sb;
    logic [NG*W-1:0] a_in, b_in;
    logic [NG*W-1:0] a_out, a_oe, b_out, b_oe;
    logic [NG-1:0]   a_en, b_en;

    int checks = 0;
    int errors = 0;

    // Behavioural reference state.
    bit m_seen [NG];
    bit m_arm  [NG];

    always #5 clk = ~clk;

    dual_xcvr_core u_dut (
        .clk(clk), .rst_n(rst_n), .oe_n_i(oe_n), .dir_i(dir),
        .scan_ovr_i(ovr), .scan_a_en_i(sa), .scan_b_en_i(sb),
        .a_in_i(a_in), .b_in_i(b_in), .a_out_o(a_out), .a_oe_o(a_oe),
        .b_out_o(b_out), .b_oe_o(b_oe), .a_en_o(a_en), .b_en_o(b_en)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the reference for the current inputs.
    task automatic compare_all();
        for (int g = 0; g < NG; g++) begin
            bit ea, eb;
            string tg;
            if (ovr[g]) begin ea = sa[g]; eb = sb[g]; tg = "R8"; end
            else if (!m_arm[g]) begin ea = 0; eb = 0; tg = "R5"; end
            else if (oe_n[g]) begin ea = 0; eb = 0; tg = "R4"; end
            else if (dir[g]) begin ea = 0; eb = 1; tg = "R2"; end
            else begin ea = 1; eb = 0; tg = "R3"; end
            chk({tg, " a_en"}, 64'(a_en[g]), 64'(ea));
            chk({tg, " b_en"}, 64'(b_en[g]), 64'(eb));
            chk("R7 a_oe", 64'(a_oe[g*W +: W]), ea ? 64'h1ff : 64'h0);
            chk("R7 b_oe", 64'(b_oe[g*W +: W]), eb ? 64'h1ff : 64'h0);
        end
        chk("R9 a_out", 64'(a_out), 64'(b_in));
        chk("R9 b_out", 64'(b_out), 64'(a_in));
    endtask

    // Apply inputs, check, then advance one clock with the model.
    task automatic step();
        #1;
        compare_all();
        @(posedge clk);
        for (int g = 0; g < NG; g++) begin
            if (!rst_n) begin m_seen[g] = 0; m_arm[g] = 0; end
            else begin
                if (m_seen[g] && !oe_n[g]) m_arm[g] = 1;
                if (oe_n[g]) m_seen[g] = 1;
            end
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        for (int g = 0; g < NG; g++) begin m_seen[g] = 0; m_arm[g] = 0; end
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; oe_n = '0; dir = '0; ovr = '0; sa = '0; sb = '0;
        a_in = 18'h2a5a5; b_in = 18'h15a5a;
        do_reset();

        // R5: reset state, enable held low never arms.
        #1;
        chk("R5 reset a_oe", 64'(a_oe), 64'h0);
        chk("R5 reset b_oe", 64'(b_oe), 64'h0);
        for (int i = 0; i < 4; i++) begin dir = NG'(i); step(); end

        // R8: override works while unarmed.
        ovr = 2'b11; sa = 2'b01; sb = 2'b10; step();
        sa = 2'b11; sb = 2'b11; step();
        ovr = 2'b00;

        // R1: arm only group 0; group 1 stays low throughout.
        oe_n = 2'b01; dir = 2'b11; step();
        oe_n = 2'b00; step();
        #1;
        chk("R1 group0 armed b_en", 64'(b_en[0]), 64'd1);
        chk("R1 group1 quiet b_oe", 64'(b_oe[17:9]), 64'h0);
        @(negedge clk);

        // Arm group 1, exercise directions and idle.
        oe_n = 2'b10; step();
        oe_n = 2'b00; dir = 2'b01; step();
        dir = 2'b10; step();
        oe_n = 2'b11; step();

        // R6: toggling keeps arming.
        oe_n = 2'b00; dir = 2'b00; step();
        #1;
        chk("R6 still armed a_oe", 64'(a_oe), 64'h3ffff);
        @(negedge clk);

        // Random traffic against the model.
        for (int i = 0; i < 300; i++) begin
            oe_n = NG'($urandom); dir = NG'($urandom);
            ovr = (($urandom % 8) == 0) ? NG'($urandom) : '0;
            sa = NG'($urandom); sb = NG'($urandom);
            a_in = 18'($urandom); b_in = 18'($urandom);
            step();
        end

        // R10: reset relocks both groups.
        ovr = '0; oe_n = '0; dir = 2'b01;
        do_reset();
        #1;
        chk("R10 relocked a_en", 64'(a_en), 64'h0);
        chk("R10 relocked b_en", 64'(b_en), 64'h0);
        @(negedge clk);
        step();
        for (int i = 0; i < 200; i++) begin
            oe_n = NG'($urandom); dir = NG'($urandom);
            a_in = 18'($urandom); b_in = 18'($urandom);
            step();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule